// File: doc/BRIEF.md
# Two-Wire Serial Port with Address-Matching Slave and Bit-Level Master

This block attaches a two-wire serial bus (a data line and a clock line, both open-drain) to a processor's register space. It has two modes, selected by one bit of its control byte. In slave mode an autonomous engine watches the bus for a start condition. It compares the incoming 7-bit address with a programmable own address, and then either receives bytes into the data register or sends bytes out of it. After every data byte it raises an interrupt flag. In master mode that engine is held off and software moves the bus one bit at a time: one control bit sets the clock line, two bits set and enable the data line, and a fourth bit captures the data line on each rising clock.

Software sees three byte-wide registers behind a 2-bit select: control/status, own address and data. A register write takes effect at the next clock edge and never stalls. Reads are combinational and have no side effects, so the register port has no back-pressure and needs no handshake. The bus pins are modelled as drive-low enables. Each line is read back through a two-flop synchronizer, and the slave acts on the edges of the synchronized lines.

Top module: `tws_port`

## Requirements
- R1: After reset the control byte reads 0x00, the own-address byte reads 0x55, the data byte reads 0x00, and neither line is driven low.
- R2: reg_sel 0 selects control, 1 selects own address and 2 selects data. The own address is writable and reads back what was written, and it changes only on a write to select 1.
- R3: With control bit 3 = 1 (software master), the data line is pulled low exactly when bit 6 (data enable) is 1 and bit 7 (data out) is 0. The clock line is pulled low exactly when bit 5 (clock out) is 0.
- R4: In master mode with bit 6 = 0, control bit 4 takes the synchronized data-line level at each rising edge of the synchronized clock line. It holds its value while bit 6 = 1, and software writes to bit 4 are ignored.
- R5: With bit 3 = 0 (hardware slave), bits 7 to 5 have no effect on the lines. The clock line is never pulled low.
- R6: The slave acknowledges (pulls data low for the ninth clock) only when the first 7 bits after a start condition, MSB first, equal own-address bits 6..0. The 8th bit selects read (1) or write (0). On a mismatch the slave leaves the line released and sets no flag.
- R7: In a write transfer each received byte, MSB first, is placed in the data register, the flag is set, and the byte is acknowledged on the ninth clock.
- R8: In a read transfer the slave sends the data register MSB first, changing the line after the falling clock. A master acknowledge loads the current data register as the next byte. A master non-acknowledge returns the slave to idle with the line released.
- R9: Control bit 0 (also the irq pin) is set by hardware after each byte sent or received. It is cleared only by a control write with bit 0 = 0, and a control write with bit 0 = 1 never sets it.
- R10: Control bit 1 reads 1 while the slave is transmitting and 0 while it is receiving or idle. Software writes to it are ignored.
- R11: While control bit 2 (slave reset) is 1, the slave engine is idle and releases the data line. After bit 2 returns to 0, it answers the next addressed transfer.
- R12: A stop condition (data rising while the clock is high) returns the slave to idle, even in the middle of a byte. Bits clocked in after that without a new start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 own address, 2 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the selected register |
| irq | output | 1 | Byte-complete flag (control bit 0) |
| sda_in | input | 1 | Data-line level as seen on the bus |
| scl_in | input | 1 | Clock-line level as seen on the bus |
| sda_drive_low | output | 1 | Pull the data line low when 1 |
| scl_drive_low | output | 1 | Pull the clock line low when 1 |

## Verification
The embedded assertions check several things on every cycle. The flag rises only on a byte-complete event and falls only on a clearing control write. The own address changes only when written. A disabled or stopped slave releases the data line. The transmit-direction bit is set throughout byte transmission. The captured master input holds whenever capture is not enabled, and the clock line stays released in slave mode. Only the bench's bus scenarios can show the protocol itself: address match and mismatch, acknowledge timing, byte order in both directions, reload on master acknowledge, end on non-acknowledge, a stop in the middle of a byte, and recovery after a slave reset. The bench also compares the master-mode pin drives against its own model on every clock.

// File: rtl/tws_pkg.sv
package tws_pkg;

  // register select codes
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  // control byte bit positions
  localparam int B_MDO  = 7;
  localparam int B_MDE  = 6;
  localparam int B_MCO  = 5;
  localparam int B_MDI  = 4;
  localparam int B_MODE = 3;
  localparam int B_SRST = 2;
  localparam int B_DIR  = 1;
  localparam int B_IRQ  = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_ACK_TX
  } slv_state_t;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= RST_VAL;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              scl,
  input  logic              sda,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sda_low,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              dir
);

  localparam int              CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  slv_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              scl_q, sda_q;
  logic              rw, seen, acked;

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_c  = scl & scl_q & sda_q & ~sda;
  assign stop_c   = scl & scl_q & ~sda_q & sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      rw        <= 1'b0;
      seen      <= 1'b0;
      acked     <= 1'b0;
      sda_low   <= 1'b0;
      rx_valid  <= 1'b0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      dir       <= 1'b0;
    end else begin
      scl_q     <= scl;
      sda_q     <= sda;
      rx_valid  <= 1'b0;
      byte_done <= 1'b0;
      if (!en || stop_c) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
        dir     <= 1'b0;
        cnt     <= '0;
      end else if (start_c) begin
        state   <= ST_ADDR;
        sda_low <= 1'b0;
        dir     <= 1'b0;
        cnt     <= '0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (sh[BYTE_W-1:1] == own_addr) begin
                state   <= ST_ACK_ADDR;
                rw      <= sh[0];
                sda_low <= 1'b1;
                seen    <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_rise) begin
              seen <= 1'b1;
            end else if (scl_fall && seen) begin
              cnt <= '0;
              if (rw) begin
                state   <= ST_TX;
                sh      <= tx_byte;
                sda_low <= ~tx_byte[BYTE_W-1];
                dir     <= 1'b1;
              end else begin
                state   <= ST_RX;
                sda_low <= 1'b0;
                dir     <= 1'b0;
              end
            end
          end
          ST_RX: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              state     <= ST_ACK_RX;
              sda_low   <= 1'b1;
              seen      <= 1'b0;
              rx_valid  <= 1'b1;
              rx_byte   <= sh;
              byte_done <= 1'b1;
            end
          end
          ST_ACK_RX: begin
            if (scl_rise) begin
              seen <= 1'b1;
            end else if (scl_fall && seen) begin
              state   <= ST_RX;
              cnt     <= '0;
              sda_low <= 1'b0;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                state     <= ST_ACK_TX;
                sda_low   <= 1'b0;
                seen      <= 1'b0;
                byte_done <= 1'b1;
              end else begin
                sh      <= sh << 1;
                sda_low <= ~sh[BYTE_W-2];
              end
            end
          end
          ST_ACK_TX: begin
            if (scl_rise) begin
              seen  <= 1'b1;
              acked <= ~sda;
            end else if (scl_fall && seen) begin
              cnt <= '0;
              if (acked) begin
                state   <= ST_TX;
                sh      <= tx_byte;
                sda_low <= ~tx_byte[BYTE_W-1];
              end else begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
                dir     <= 1'b0;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R11: a held-off engine lets go of the data line
  p_disabled_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sda_low)
    else $error("p_disabled_release_r11");

  // R12: stop condition always lands in idle with the line released
  p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_c) |=> (state == ST_IDLE && !sda_low))
    else $error("p_stop_idle_r12");

  // R10: direction reads transmit during every transmitted bit
  p_tx_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX) |-> dir)
    else $error("p_tx_dir_r10");

endmodule

// File: rtl/tws_port.sv
module tws_port
  import tws_pkg::*;
#(
  parameter int              DATA_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ADDR_RST  = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_drive_low,
  output logic              scl_drive_low
);

  logic scl_s, sda_s, scl_s_q;
  logic mdo, mde, mco, mdi, mode, srst, irq_q;
  logic [DATA_W-1:0] own_addr_q, data_q;

  logic              slv_sda_low, slv_rx_valid, slv_done, slv_dir;
  logic [DATA_W-1:0] slv_rx_byte;

  logic wr_ctrl, wr_addr, wr_data;
  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
  assign wr_addr = reg_wr && (reg_sel == SEL_ADDR);
  assign wr_data = reg_wr && (reg_sel == SEL_DATA);

  tws_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_in, sda_in}),
    .q     ({scl_s, sda_s})
  );

  tws_slave #(.BYTE_W(DATA_W)) u_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (~mode & ~srst),
    .scl       (scl_s),
    .sda       (sda_s),
    .own_addr  (own_addr_q[DATA_W-2:0]),
    .tx_byte   (data_q),
    .sda_low   (slv_sda_low),
    .rx_valid  (slv_rx_valid),
    .rx_byte   (slv_rx_byte),
    .byte_done (slv_done),
    .dir       (slv_dir)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s_q    <= 1'b1;
      mdo        <= 1'b0;
      mde        <= 1'b0;
      mco        <= 1'b0;
      mdi        <= 1'b0;
      mode       <= 1'b0;
      srst       <= 1'b0;
      irq_q      <= 1'b0;
      own_addr_q <= ADDR_RST;
      data_q     <= '0;
    end else begin
      scl_s_q <= scl_s;
      if (wr_ctrl) begin
        mdo  <= reg_wdata[B_MDO];
        mde  <= reg_wdata[B_MDE];
        mco  <= reg_wdata[B_MCO];
        mode <= reg_wdata[B_MODE];
        srst <= reg_wdata[B_SRST];
        if (!reg_wdata[B_IRQ]) irq_q <= 1'b0;
      end
      if (slv_done) irq_q <= 1'b1;
      if (mode && !mde && scl_s && !scl_s_q) mdi <= sda_s;
      if (wr_addr) own_addr_q <= reg_wdata;
      if (slv_rx_valid)  data_q <= slv_rx_byte;
      else if (wr_data)  data_q <= reg_wdata;
    end
  end

  assign sda_drive_low = mode ? (mde & ~mdo) : slv_sda_low;
  assign scl_drive_low = mode & ~mco;
  assign irq           = irq_q;

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {mdo, mde, mco, mdi, mode, srst, slv_dir, irq_q};
      SEL_ADDR: reg_rdata = own_addr_q;
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

  // R9: flag cannot rise without a completed byte
  p_irq_hw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !slv_done) |=> !irq_q)
    else $error("p_irq_hw_set_r9");

  // R9: flag cannot fall without a clearing control write
  p_irq_sw_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(wr_ctrl && !reg_wdata[B_IRQ])) |=> irq_q)
    else $error("p_irq_sw_clear_r9");

  // R2: own address is only changed by its write
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_addr |=> $stable(own_addr_q))
    else $error("p_addr_hold_r2");

  // R4: captured input holds when capture is not enabled
  p_mdi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mde || !mode) |=> $stable(mdi))
    else $error("p_mdi_hold_r4");

  // R5: slave mode never pulls the clock line
  p_slave_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> !scl_drive_low)
    else $error("p_slave_scl_r5");

endmodule

// File: tb/tws_port_tb.sv
`timescale 1ns/1ps
module tws_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;
  logic       sda_drive_low, scl_drive_low;
  logic       sda_m = 1'b1, scl_m = 1'b1;
  logic       sda_line, scl_line;

  int n_chk = 0;
  int n_fail = 0;
  int n_cyc_bad = 0;

  // bench-side model of the software-master pin drives
  logic m_mode = 1'b0, m_mco = 1'b0, m_mde = 1'b0, m_mdo = 1'b0;

  assign sda_line = sda_m & ~sda_drive_low;
  assign scl_line = scl_m & ~scl_drive_low;

  always #5 clk = ~clk;

  tws_port dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .sda_in        (sda_line),
    .scl_in        (scl_line),
    .sda_drive_low (sda_drive_low),
    .scl_drive_low (scl_drive_low)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk);
    reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
    if (sel == 2'd0) begin
      m_mdo = v[7]; m_mde = v[6]; m_mco = v[5]; m_mode = v[3];
    end
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; idle(10);
    sda_m = 1'b0; idle(10);
    scl_m = 1'b0; idle(10);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; idle(5);
    scl_m = 1'b1; idle(10);
    sda_m = 1'b1; idle(10);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; idle(5);
    scl_m = 1'b1; idle(10);
    scl_m = 1'b0; idle(5);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; idle(5);
    scl_m = 1'b1; idle(5);
    b = sda_line; idle(5);
    scl_m = 1'b0; idle(5);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
  endtask

  // per-clock comparison of pin drives against the model (R3, R5)
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (scl_drive_low !== (m_mode & ~m_mco) ||
          (m_mode && sda_drive_low !== (m_mde & ~m_mdo))) begin
        n_cyc_bad++;
        if (n_cyc_bad <= 5)
          $display("FAIL R3/R5 pins actual scl=%0b sda=%0b expected scl=%0b sda=%0b",
                   scl_drive_low, sda_drive_low, m_mode & ~m_mco, m_mde & ~m_mdo);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       b;
    idle(4);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    cpu_read(2'd0, v); chk("R1 ctrl", v, 8'h00);
    cpu_read(2'd1, v); chk("R1 addr", v, 8'h55);
    cpu_read(2'd2, v); chk("R1 data", v, 8'h00);
    chk("R1 sda drive", sda_drive_low, 0);
    chk("R1 scl drive", scl_drive_low, 0);

    // R3 master pin control
    cpu_write(2'd0, 8'h68); idle(1);
    chk("R3 sda low (mde=1,mdo=0)", sda_drive_low, 1);
    chk("R3 scl released (mco=1)", scl_drive_low, 0);
    cpu_write(2'd0, 8'hE8); idle(1);
    chk("R3 sda released (mdo=1)", sda_drive_low, 0);
    cpu_write(2'd0, 8'h48); idle(1);
    chk("R3 scl low (mco=0)", scl_drive_low, 1);

    // R4 input capture on rising clock
    cpu_write(2'd0, 8'h08); sda_m = 1'b1; idle(4);
    cpu_write(2'd0, 8'h28); idle(6);
    cpu_read(2'd0, v); chk("R4 capture high", v[4], 1);
    sda_m = 1'b0;
    cpu_write(2'd0, 8'h08); idle(4);
    cpu_write(2'd0, 8'h28); idle(6);
    cpu_read(2'd0, v); chk("R4 capture low", v[4], 0);
    sda_m = 1'b1;
    cpu_write(2'd0, 8'h48); idle(4);
    cpu_write(2'd0, 8'h68); idle(6);
    cpu_read(2'd0, v); chk("R4 hold while enabled", v[4], 0);
    cpu_write(2'd0, 8'h18); idle(6);
    cpu_read(2'd0, v); chk("R4 write to bit4 ignored", v[4], 0);

    // R5 slave mode ignores master bits
    sda_m = 1'b1; scl_m = 1'b1;
    cpu_write(2'd0, 8'h40); idle(4);
    chk("R5 sda not driven", sda_drive_low, 0);
    chk("R5 scl not driven", scl_drive_low, 0);
    cpu_write(2'd0, 8'h00); idle(4);

    // R2 address register
    cpu_write(2'd1, 8'h3A);
    cpu_read(2'd1, v); chk("R2 addr readback", v, 8'h3A);
    cpu_read(2'd3, v); chk("R2 unused select", v, 8'h00);

    // R6 mismatch (old address 0x55, write)
    bus_start(); send_byte(8'hAA); get_bit(b);
    chk("R6 no ack on mismatch", b, 1);
    chk("R6 no flag on mismatch", irq, 0);
    bus_stop();

    // R6/R7 write transfer
    bus_start(); send_byte(8'h74); get_bit(b);
    chk("R6 ack on match", b, 0);
    send_byte(8'hC3); get_bit(b);
    chk("R7 data ack", b, 0);
    cpu_read(2'd2, v); chk("R7 rx byte 1", v, 8'hC3);
    cpu_read(2'd0, v); chk("R9 flag set after rx", v[0], 1);
    chk("R9 irq pin", irq, 1);
    chk("R10 dir while receiving", v[1], 0);
    cpu_write(2'd0, 8'h00);
    cpu_read(2'd0, v); chk("R9 cleared by write 0", v[0], 0);
    cpu_write(2'd0, 8'h01);
    cpu_read(2'd0, v); chk("R9 write 1 does not set", v[0], 0);
    cpu_write(2'd0, 8'h00);
    send_byte(8'h5A); get_bit(b);
    chk("R7 second ack", b, 0);
    cpu_read(2'd2, v); chk("R7 rx byte 2", v, 8'h5A);
    bus_stop(); idle(4);
    chk("R12 released after stop", sda_drive_low, 0);
    cpu_write(2'd0, 8'h02);
    cpu_read(2'd0, v); chk("R10 dir write ignored", v[1], 0);

    // R8 read transfer
    cpu_write(2'd2, 8'hA5);
    bus_start(); send_byte(8'h75); get_bit(b);
    chk("R8 ack on read address", b, 0);
    cpu_read(2'd0, v); chk("R10 dir while transmitting", v[1], 1);
    recv_byte(v); chk("R8 tx byte 1", v, 8'hA5);
    chk("R9 flag after tx", irq, 1);
    cpu_write(2'd2, 8'h3C);
    cpu_write(2'd0, 8'h00);
    put_bit(1'b0);
    recv_byte(v); chk("R8 tx byte 2 after ack", v, 8'h3C);
    put_bit(1'b1); idle(4);
    chk("R8 released after nack", sda_drive_low, 0);
    cpu_read(2'd0, v); chk("R10 dir after nack", v[1], 0);
    bus_stop();

    // R11 slave reset during ack
    cpu_write(2'd0, 8'h00);
    bus_start(); send_byte(8'h74);
    chk("R6 ack drive during ninth clock", sda_drive_low, 1);
    cpu_write(2'd0, 8'h04); idle(2);
    chk("R11 released by reset", sda_drive_low, 0);
    get_bit(b); chk("R11 no ack while reset", b, 1);
    bus_stop();
    cpu_write(2'd0, 8'h00);
    bus_start(); send_byte(8'h74); get_bit(b);
    chk("R11 works after reset released", b, 0);

    // R12 stop in middle of a byte
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b0);
    bus_stop();
    scl_m = 1'b0; idle(5);
    send_byte(8'h74); get_bit(b);
    chk("R12 no ack without new start", b, 1);
    sda_m = 1'b1; scl_m = 1'b1; idle(10);

    chk("R3/R5 per-cycle pin mismatches", n_cyc_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule